// File: doc/BRIEF.md
# Supply-Supervised Reset Pulse Controller

This block drives the reset of a microprocessor from three sources: a synchronous supply-in-tolerance flag produced by an external comparator, a watchdog-timeout request and a mechanical pushbutton. A threshold-status output shows the supply condition in the same cycle, with no delay. Two reset outputs, one active-low and one active-high, assert as soon as any cause appears. They stay asserted for a minimum hold time after the last cause clears, so that the supply and the processor can settle before software runs.

All timing comes from a single-cycle `tick` strobe supplied from outside. The hold time and the pushbutton debounce interval are parameters expressed as tick counts. With a 1 kHz tick, the default hold of 100 ticks gives a 100 ms reset stretch.

Top module: `rst_pulse_ctrl`

## Requirements
- R1: While the synchronous reset `rst` is high, `vth_low` is 1, `rst_out` is 1 and `rst_out_n` is 0. After `rst` falls, the reset outputs stay active until HOLD_TICKS ticks have been counted.
- R2: `vth_low` equals the inverse of `supply_ok` in the same cycle (combinational, no register), whenever `rst` is low.
- R3: When `supply_ok` is 0, `rst_out` is 1 and `rst_out_n` is 0 in that same cycle.
- R4: When the last reset cause clears, the reset outputs are released right after the clock edge that samples the HOLD_TICKS-th tick. Only ticks at edges where no cause is present are counted. This holds for any spacing between ticks.
- R5: `rst_out_n` is always the complement of `rst_out`.
- R6: A high `wd_expire` makes both reset outputs active in the same cycle and reloads the full hold.
- R7: `btn_n` is active low (0 = pressed). It passes a two-flop synchronizer, then must be seen pressed at DEB_TICKS consecutive tick edges before it counts as a reset cause. A shorter press has no effect on the reset outputs.
- R8: Button release is debounced in the same way. The full hold starts once the debounced release takes effect.
- R9: A reset cause that appears while a hold is in progress restarts the hold from its full length.
- R10: The hold counter never counts during a cause, and release happens only at a tick edge where the counter reaches zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| tick | input | 1 | Timebase strobe, one cycle wide |
| supply_ok | input | 1 | Supply in tolerance (synchronous comparator result) |
| wd_expire | input | 1 | Watchdog timeout request |
| btn_n | input | 1 | Pushbutton, active low, asynchronous |
| vth_low | output | 1 | Supply below threshold, undelayed |
| rst_out | output | 1 | Stretched reset, active high |
| rst_out_n | output | 1 | Stretched reset, active low |

## Verification
The bench builds the block with HOLD_TICKS = 5 and DEB_TICKS = 3. With these values every step of the hold countdown and every debounce tick can be checked one by one. The hold release is swept over tick spacings of one to four cycles, which shows that only ticks are counted and not clock cycles. The small debounce count makes it practical to cover a press one tick too short and a press of exactly the required length. A cause is also injected partway through a hold to exercise the restart.

// File: rtl/rst_pulse_ctrl.sv
module rst_pulse_ctrl #(
  parameter int HOLD_TICKS = 100,
  parameter int DEB_TICKS  = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic supply_ok,
  input  logic wd_expire,
  input  logic btn_n,
  output logic vth_low,
  output logic rst_out,
  output logic rst_out_n
);

  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int DW = $clog2(DEB_TICKS + 1);
  localparam logic [HW-1:0] HOLD_LD  = HW'(HOLD_TICKS);
  localparam logic [DW-1:0] DEB_LAST = DW'(DEB_TICKS - 1);

  logic [1:0]    btn_sync;
  logic          btn_state;
  logic [DW-1:0] deb_cnt;
  logic [HW-1:0] hold_cnt;
  logic          cause;

  always_ff @(posedge clk) begin
    if (rst) btn_sync <= 2'b11;
    else     btn_sync <= {btn_sync[0], btn_n};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      btn_state <= 1'b0;
      deb_cnt   <= '0;
    end else if (~btn_sync[1] == btn_state) begin
      deb_cnt <= '0;
    end else if (tick) begin
      if (deb_cnt == DEB_LAST) begin
        btn_state <= ~btn_sync[1];
        deb_cnt   <= '0;
      end else begin
        deb_cnt <= deb_cnt + 1'b1;
      end
    end
  end

  assign cause = ~supply_ok | wd_expire | btn_state;

  always_ff @(posedge clk) begin
    if (rst || cause)               hold_cnt <= HOLD_LD;
    else if (tick && hold_cnt != 0) hold_cnt <= hold_cnt - 1'b1;
  end

  assign vth_low   = rst | ~supply_ok;
  assign rst_out   = rst | cause | (hold_cnt != 0);
  assign rst_out_n = ~rst_out;

  AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |-> (rst_out && vth_low)); // R3
  AST_VTH_CLEAR: assert property (@(posedge clk) disable iff (rst)
    supply_ok |-> !vth_low); // R2
  AST_WD_FORCE: assert property (@(posedge clk) disable iff (rst)
    wd_expire |-> (rst_out && !rst_out_n)); // R6
  AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (rst)
    cause |=> (hold_cnt == HOLD_LD)); // R9
  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_out) |-> ($past(tick) && $past(hold_cnt) == 1)); // R10
  AST_DEB_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(btn_state) |-> $past(tick)); // R7

endmodule

// File: tb/rst_pulse_ctrl_tb_top.sv
module rst_pulse_ctrl_tb_top;
  localparam int HOLD = 5;
  localparam int DEB  = 3;

  logic clk = 0;
  logic rst = 1, tick = 0, supply_ok = 1, wd_expire = 0, btn_n = 1;
  logic vth_low, rst_out, rst_out_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rst_pulse_ctrl #(.HOLD_TICKS(HOLD), .DEB_TICKS(DEB)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .supply_ok(supply_ok),
    .wd_expire(wd_expire), .btn_n(btn_n),
    .vth_low(vth_low), .rst_out(rst_out), .rst_out_n(rst_out_n));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cyc(input logic t);
    tick = t;
    @(posedge clk);
    #1;
    tick = 0;
  endtask

  task automatic rst_chk(input string req, input logic exp);
    chk(req, rst_out, exp);
    chk("R5", rst_out_n, ~exp);
  endtask

  task automatic hold_out(input string req, input int gap);
    for (int i = 1; i <= HOLD; i++) begin
      for (int g = 1; g < gap; g++) cyc(0);
      cyc(1);
      rst_chk(req, (i < HOLD) ? 1'b1 : 1'b0);
    end
  endtask

  initial begin
    #1;
    repeat (3) cyc(1);
    chk("R1", vth_low, 1'b1);
    rst_chk("R1", 1'b1);
    rst = 0;
    #1;
    chk("R2", vth_low, 1'b0);
    repeat (3) cyc(0);
    rst_chk("R1", 1'b1);
    hold_out("R1", 1);

    for (int gap = 1; gap <= 4; gap++) begin
      supply_ok = 0;
      #1;
      chk("R2", vth_low, 1'b1);
      rst_chk("R3", 1'b1);
      cyc(1); cyc(1);
      rst_chk("R10", 1'b1);
      supply_ok = 1;
      #1;
      chk("R2", vth_low, 1'b0);
      rst_chk("R4", 1'b1);
      hold_out("R4", gap);
    end

    wd_expire = 1;
    #1;
    rst_chk("R6", 1'b1);
    cyc(1);
    wd_expire = 0;
    hold_out("R6", 2);

    supply_ok = 0; cyc(0); supply_ok = 1;
    cyc(1); cyc(1); cyc(1);
    rst_chk("R9", 1'b1);
    wd_expire = 1; cyc(0); wd_expire = 0;
    hold_out("R9", 1);

    btn_n = 0;
    cyc(0); cyc(0);
    for (int k = 1; k < DEB; k++) begin
      cyc(1);
      rst_chk("R7", 1'b0);
    end
    btn_n = 1;
    cyc(0); cyc(0); cyc(0);
    for (int k = 0; k < 6; k++) begin
      cyc(1);
      rst_chk("R7", 1'b0);
    end

    btn_n = 0;
    cyc(0); cyc(0);
    for (int k = 1; k < DEB; k++) cyc(1);
    rst_chk("R7", 1'b0);
    cyc(1);
    rst_chk("R7", 1'b1);
    repeat (8) cyc(1);
    rst_chk("R7", 1'b1);
    btn_n = 1;
    cyc(0); cyc(0);
    for (int k = 1; k < DEB; k++) begin
      cyc(1);
      rst_chk("R8", 1'b1);
    end
    cyc(1);
    rst_chk("R8", 1'b1);
    hold_out("R8", 3);

    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule